// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block watches the demodulated output of an infrared receiver and turns a remote-control burst into a list of timed levels. A prescaler divides the system clock by four, and a programmable period counter derives a sample tick from that slower clock. On every tick the synchronized input level is examined. The block measures how many consecutive ticks each low level (mark) and each high level (space) lasts. Each length is stored as an 8-bit saturating count in a bank of seventeen 32-bit words, four counts per word.

Capture waits for the first mark. A space that lasts 255 ticks closes the message, and so does filling all 68 entries. Either event sets an interrupt status bit and freezes the bank until software writes the restart bit. The restart clears every capture word and re-arms the receiver. Software reads the words through a plain single-cycle register port and hands the list to a protocol decoder.

Top module: `ir_capture_ctrl`

## Requirements
- R1: The bank changes only while both enables are set: bit 0 (receiver on) and bit 13 (width measurement on) of the register at 0x0C. With either one clear, input edges leave every capture word at its previous value.
- R2: The sample tick occurs once every 4*P system clocks. P is the 13-bit field in bits 20:8 of the register at 0x10. Its reset value is 0xC00, and P=0 behaves as P=1.
- R3: Each stored length is the number of sample ticks that saw the level. A level seen on 255 or more ticks is stored as 0xFF.
- R4: High input before the first low sample is not recorded. Entry 0 is a mark, and later entries alternate space, mark, space, and so on.
- R5: Entry n is held in bits 8*(n mod 4)+7 : 8*(n mod 4) of the capture word at byte offset 0x88 + 4*floor(n/4), for words 0 to 16.
- R6: When a space reaches 255 ticks, 0xFF is stored as its entry, the message ends, and bit 0 of the status read at 0xD0 becomes 1.
- R7: When entry 67 is written, the status is set. After a message end or a full bank, further input changes alter no capture word until a restart.
- R8: Writing a 1 to bit 0 of offset 0x20 sets all capture words to zero and re-arms capture, which then waits for a new first mark.
- R9: `irq` is high exactly when the status is set and bit 0 of the register at 0xCC is 1. Writing a 1 to bit 0 of offset 0xD0 clears the status. The status is read back in bit 0 of 0xD0.
- R10: The input passes through a two-flop synchronizer, and a low level counts as a mark.
- R11: A read of any offset other than 0x0C, 0x10, 0xCC, 0xD0 and the word-aligned capture offsets returns zero. This includes 0x20 and unaligned addresses inside the capture range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_rx | input | 1 | Demodulated receiver output, low during a mark |
| bus_we | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds each input level for an exact multiple of the sample period, so the stored counts are known exactly whatever the tick phase. It sweeps the period setting through 0 to 3 and several length patterns.

A design that counts one tick too many or too few, or that records the leading idle space, shifts every byte of the bank. A packing error puts counts in the wrong byte lane. Two further cases target the end of capture: a mark longer than 255 ticks must saturate without closing the message, and a 70-level burst must stop at exactly 68 entries. A design that wraps its counter, or that keeps writing after the bank fills, fails these.

The bench also checks that:
- capture stays off with only one enable set;
- the interrupt is masked by its enable;
- the restart zeroes the bank.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cap_state_e;

    localparam int OFS_CFG_EN     = 'h0C;
    localparam int OFS_CFG_PERIOD = 'h10;
    localparam int OFS_RESTART    = 'h20;
    localparam int OFS_BANK_BASE  = 'h88;
    localparam int OFS_IRQ_MASK   = 'hCC;
    localparam int OFS_IRQ_STAT   = 'hD0;

    localparam int BIT_RX_ON      = 0;
    localparam int BIT_MEASURE_ON = 13;
    localparam int PERIOD_LSB     = 8;

endpackage

// File: rtl/ir_in_sync.sv
module ir_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.sh = {q.sh[STAGES-2:0], raw_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1};
        else        q <= d;
    end

    assign level = q.sh[STAGES-1];

endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV      = 4,
    parameter int PERIOD_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                sample_tick
);

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0]    div;
        logic [PERIOD_W-1:0] per;
    } tick_t;

    tick_t d, q;
    logic  div_wrap;
    logic  per_hit;

    assign div_wrap    = (q.div == DIV_LAST);
    assign per_hit     = ({1'b0, q.per} + (PERIOD_W+1)'(1)) >= {1'b0, period};
    assign sample_tick = run && div_wrap && per_hit;

    always_comb begin
        d = q;
        if (!run) begin
            d = '0;
        end else if (div_wrap) begin
            d.div = '0;
            d.per = per_hit ? '0 : q.per + 1'b1;
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: the period counter never runs past a nonzero setting
    p_period_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period != '0 && $stable(period) && $past(run)) |-> (q.per < period || $past(q.per) >= period));

endmodule

// File: rtl/ir_pw_recorder.sv
module ir_pw_recorder
    import ir_cap_pkg::*;
#(
    parameter int ENTRIES = 68,
    parameter int CNT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_tick,
    input  logic                     mark,
    input  logic                     restart,
    output logic [ENTRIES*CNT_W-1:0] bank,
    output logic                     evt,
    output logic                     frozen
);

    localparam int IDX_W = $clog2(ENTRIES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(ENTRIES);

    typedef struct packed {
        cap_state_e                     st;
        logic [IDX_W-1:0]               idx;
        logic [CNT_W-1:0]               cnt;
        logic                           lvl;
        logic                           evt;
        logic [ENTRIES-1:0][CNT_W-1:0]  bank;
    } rec_t;

    rec_t d, q;

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        if (restart) begin
            d.st   = ST_IDLE;
            d.idx  = '0;
            d.cnt  = '0;
            d.lvl  = 1'b0;
            d.bank = '0;
        end else if (sample_tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (mark) begin
                        d.st  = ST_RUN;
                        d.lvl = 1'b1;
                        d.cnt = CNT_ONE;
                    end
                end
                ST_RUN: begin
                    if (mark == q.lvl) begin
                        if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                        if (!q.lvl && q.cnt == CNT_MAX - 1'b1) begin
                            d.bank[q.idx] = CNT_MAX;
                            d.idx         = q.idx + 1'b1;
                            d.st          = ST_DONE;
                            d.evt         = 1'b1;
                        end
                    end else begin
                        d.bank[q.idx] = q.cnt;
                        d.idx         = q.idx + 1'b1;
                        if (q.idx == IDX_LAST) begin
                            d.st  = ST_DONE;
                            d.evt = 1'b1;
                        end else begin
                            d.lvl = mark;
                            d.cnt = CNT_ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bank   = q.bank;
    assign evt    = q.evt;
    assign frozen = (q.st == ST_DONE);

    // R3: a level being measured never shows a wrapped (zero) count
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> (q.cnt != '0));

    // R4: nothing is stored while waiting for the first mark
    p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (q.idx == '0));

    // R5: the write pointer never leaves the bank
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_FULL);

    // R7: a finished capture holds its contents until restart
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE && !restart) |=> (q.st == ST_DONE && $stable(q.bank)));

    // R8: restart empties the bank and re-arms
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.bank == '0 && q.st == ST_IDLE));

endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
    import ir_cap_pkg::*;
#(
    parameter int                  WORDS       = 17,
    parameter int                  CNT_W       = 8,
    parameter int                  CLK_DIV     = 4,
    parameter int                  PERIOD_W    = 13,
    parameter int                  ADDR_W      = 8,
    parameter int                  DATA_W      = 32,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [PERIOD_W-1:0] PERIOD_RST  = 13'hC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_rx,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int LANES   = DATA_W / CNT_W;
    localparam int ENTRIES = WORDS * LANES;
    localparam int SEL_W   = ADDR_W - 2;

    typedef struct packed {
        logic                rx_on;
        logic                meas_on;
        logic [PERIOD_W-1:0] period;
        logic                irq_mask;
        logic                status;
    } regs_t;

    regs_t d, q;

    logic                     rx_level;
    logic                     tick;
    logic                     cap_on;
    logic                     restart_w;
    logic                     clear_w;
    logic                     rec_evt;
    logic                     rec_frozen;
    logic [ENTRIES*CNT_W-1:0] bank_flat;
    logic [DATA_W-1:0]        words [WORDS];
    logic [ADDR_W-1:0]        bank_off;
    logic [SEL_W-1:0]         word_sel;
    logic                     in_bank;

    function automatic logic wr_at(input int ofs);
        return bus_we && (bus_addr == ADDR_W'(ofs));
    endfunction

    assign cap_on    = q.rx_on && q.meas_on;
    assign restart_w = wr_at(OFS_RESTART) && bus_wdata[0];
    assign clear_w   = wr_at(OFS_IRQ_STAT) && bus_wdata[0];

    ir_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (ir_rx),
        .level  (rx_level)
    );

    ir_tick_gen #(.DIV(CLK_DIV), .PERIOD_W(PERIOD_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cap_on),
        .period      (q.period),
        .sample_tick (tick)
    );

    ir_pw_recorder #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (tick),
        .mark        (~rx_level),
        .restart     (restart_w),
        .bank        (bank_flat),
        .evt         (rec_evt),
        .frozen      (rec_frozen)
    );

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign words[w] = bank_flat[w*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        d = q;
        if (wr_at(OFS_CFG_EN)) begin
            d.rx_on   = bus_wdata[BIT_RX_ON];
            d.meas_on = bus_wdata[BIT_MEASURE_ON];
        end
        if (wr_at(OFS_CFG_PERIOD)) d.period   = bus_wdata[PERIOD_LSB +: PERIOD_W];
        if (wr_at(OFS_IRQ_MASK))   d.irq_mask = bus_wdata[0];
        if (rec_evt)               d.status   = 1'b1;
        else if (clear_w)          d.status   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.period <= PERIOD_RST;
        end else begin
            q <= d;
        end
    end

    assign bank_off = bus_addr - ADDR_W'(OFS_BANK_BASE);
    assign word_sel = bank_off[ADDR_W-1:2];
    assign in_bank  = (bus_addr >= ADDR_W'(OFS_BANK_BASE)) && (bank_off[1:0] == 2'b00)
                      && (int'(word_sel) < WORDS);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CFG_EN)) begin
            bus_rdata[BIT_RX_ON]      = q.rx_on;
            bus_rdata[BIT_MEASURE_ON] = q.meas_on;
        end else if (bus_addr == ADDR_W'(OFS_CFG_PERIOD)) begin
            bus_rdata[PERIOD_LSB +: PERIOD_W] = q.period;
        end else if (bus_addr == ADDR_W'(OFS_IRQ_MASK)) begin
            bus_rdata[0] = q.irq_mask;
        end else if (bus_addr == ADDR_W'(OFS_IRQ_STAT)) begin
            bus_rdata[0] = q.status;
        end else if (in_bank) begin
            bus_rdata = words[word_sel];
        end
    end

    assign irq = q.status && q.irq_mask;

    // R1: with capture disabled the bank only moves on a restart
    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_on && !restart_w) |=> $stable(bank_flat));

    // R6: an end event always leaves the status set
    p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_evt |=> q.status);

    // R7: an end event is always followed by a frozen recorder until restart
    p_evt_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_evt && !restart_w) |-> rec_frozen);

    // R9: a clear with no competing event drops the status
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_w && !rec_evt) |=> !q.status);

endmodule

// File: tb/test_ir_capture_ctrl.sv
module test_ir_capture_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_rx = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int S = 8;
    bit done = 0;
    int segs [80];
    logic [7:0] exp_b [68];

    always #10 clk = ~clk;

    ir_capture_ctrl i_ir_capture_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_rx     (ir_rx),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic seg(input bit is_mark, input int n);
        ir_rx = is_mark ? 1'b0 : 1'b1;
        repeat (n * S) @(negedge clk);
    endtask

    // leading idle, n alternating levels starting with a mark, long trailing space
    task automatic drive_msg(input int n);
        @(negedge clk);
        seg(0, 5);
        for (int k = 0; k < n; k++) seg((k % 2) == 0, segs[k]);
        seg(0, 300);
    endtask

    task automatic build_exp(input int n);
        for (int k = 0; k < 68; k++) exp_b[k] = 8'h00;
        for (int k = 0; k < n && k < 68; k++) exp_b[k] = (segs[k] > 255) ? 8'hFF : 8'(segs[k]);
        if (n < 68) exp_b[n] = 8'hFF;
    endtask

    task automatic chk_bank(input string tag);
        logic [31:0] v;
        for (int w = 0; w < 17; w++) begin
            rd(8'h88 + 8'(4 * w), v);
            chk(v, {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]}, tag);
        end
    endtask

    task automatic rearm();
        wr(8'h20, 32'h1);
        wr(8'hD0, 32'h1);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'h0C, v); chk(v, 32'h0, "R1 reset enables");
        rd(8'h10, v); chk(v, 32'h000C_0000, "R2 reset period");
        rd(8'hCC, v); chk(v, 32'h0, "R9 reset mask");
        rd(8'hD0, v); chk(v, 32'h0, "R9 reset status");
        chk({31'b0, irq}, 32'h0, "R9 reset irq");
        for (int k = 0; k < 68; k++) exp_b[k] = 8'h00;
        chk_bank("R8 reset bank zero");

        // capture must stay off with a single enable
        wr(8'h10, 32'h0000_0200);
        S = 8;
        for (int k = 0; k < 5; k++) segs[k] = k + 2;
        wr(8'h0C, 32'h0000_0001);
        drive_msg(5);
        chk_bank("R1 only receiver enable");
        wr(8'h0C, 32'h0000_2000);
        drive_msg(5);
        chk_bank("R1 only measure enable");
        rd(8'hD0, v); chk(v, 32'h0, "R1 no status when disabled");

        // normal message, both enables on, interrupt enabled
        wr(8'h0C, 32'h0000_2001);
        rd(8'h0C, v); chk(v, 32'h0000_2001, "R1 enable readback");
        wr(8'hCC, 32'h1);
        for (int k = 0; k < 9; k++) segs[k] = ((k * 5) % 23) + 1;
        drive_msg(9);
        build_exp(9);
        chk_bank("R4 R5 R6 R10 message A");
        rd(8'hD0, v); chk(v, 32'h1, "R6 status after end space");
        chk({31'b0, irq}, 32'h1, "R9 irq raised");

        // mask then clear
        wr(8'hCC, 32'h0);
        chk({31'b0, irq}, 32'h0, "R9 irq masked");
        rd(8'hD0, v); chk(v, 32'h1, "R9 status kept while masked");
        wr(8'hCC, 32'h1);
        wr(8'hD0, 32'h1);
        chk({31'b0, irq}, 32'h0, "R9 irq after clear");
        rd(8'hD0, v); chk(v, 32'h0, "R9 status after clear");
        rd(8'h88, v); chk(v, {exp_b[3], exp_b[2], exp_b[1], exp_b[0]}, "R7 bank kept after clear");

        // restart wipes
        wr(8'h20, 32'h1);
        for (int k = 0; k < 68; k++) exp_b[k] = 8'h00;
        chk_bank("R8 restart clears");

        // mark saturation
        segs[0] = 300; segs[1] = 3; segs[2] = 2;
        drive_msg(3);
        build_exp(3);
        chk_bank("R3 mark saturates");
        rd(8'hD0, v); chk(v, 32'h1, "R6 status after saturated mark message");

        // full bank: 70 levels, only 68 kept
        rearm();
        for (int k = 0; k < 70; k++) segs[k] = ((k * 3) % 7) + 1;
        drive_msg(70);
        build_exp(70);
        chk_bank("R7 full bank");
        rd(8'hD0, v); chk(v, 32'h1, "R7 status on full bank");
        seg(1, 4); seg(0, 4); seg(1, 4); seg(0, 4);
        chk_bank("R7 edges ignored after full");

        // period sweep
        for (int p = 0; p < 4; p++) begin
            S = 4 * ((p == 0) ? 1 : p);
            wr(8'h10, 32'(p) << 8);
            rd(8'h10, v); chk(v, 32'(p) << 8, "R2 period readback");
            rearm();
            for (int k = 0; k < 7; k++) segs[k] = ((k * (p + 3)) % 11) + 1;
            drive_msg(7);
            build_exp(7);
            chk_bank("R2 period sweep");
            rd(8'hD0, v); chk(v, 32'h1, "R6 status in sweep");
        end

        // undefined offsets
        rd(8'h00, v); chk(v, 32'h0, "R11 offset 0x00");
        rd(8'h14, v); chk(v, 32'h0, "R11 offset 0x14");
        rd(8'h20, v); chk(v, 32'h0, "R11 restart reads zero");
        rd(8'h8A, v); chk(v, 32'h0, "R11 unaligned in bank");
        rd(8'hD4, v); chk(v, 32'h0, "R11 offset 0xD4");
        rd(8'hFC, v); chk(v, 32'h0, "R11 offset 0xFC");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule